// File: doc/BRIEF.md
# Prescaled Interval Timer Channel

A single 16-bit counter channel for a timer peripheral. Each enabled clock cycle may advance the count by one. A power-of-two prescaler selected by clock control can slow the rate. The count runs upward or downward. It either spans the full counter range or restarts over a programmable period of `interval + 1`.

On every real count step, the new count is compared with three match values. Wrap events and match hits are latched into a sticky status word. A status-read strobe returns the word and clears it. The interrupt line is raised while any latched flag is also enabled. Counter control is a stored register written through a strobe, with a self-clearing reset bit. The other settings are plain inputs, held by the surrounding register file.

Top module: `pit_channel`

## Requirements
- R1: After reset, `ctrl_q` reads 0x21, so the counter is disabled and bit 5 is set. `count`, `status` and `irq` are all 0.
- R2: A `ctrl_we` strobe stores `ctrl_wdata` with bit 4 forced to 0 in `ctrl_q`. If `ctrl_wdata` bit 4 is 1, the count becomes 0 on that edge.
- R3: While `ctrl_q` bit 0 (disable) is 1, the count holds its value.
- R4: With `clk_cfg` bit 0 = 1, the count advances once every 2^(N+1) clocks, where N = `clk_cfg[4:1]`. The prescaler phase restarts on a reset write. With `clk_cfg` bit 0 = 0, the count advances every clock, whatever N is.
- R5: With `ctrl_q` bits 2:1 = 0, the count steps up and wraps from 0xFFFF to 0. The wrap sets status bit 4 (overflow).
- R6: With `ctrl_q` bit 1 = 1 (interval mode), the count runs 0..`interval` and then returns to 0. The wrap sets status bit 0, not bit 4.
- R7: With `ctrl_q` bit 2 = 1 (down), a step from 0 loads the top value: `interval` in interval mode, otherwise 0xFFFF. This sets the same wrap flag as in R5 and R6.
- R8: With `ctrl_q` bit 3 = 1, a count step onto `match_vals[16*i +: 16]` sets status bit i+1 (i = 0..2). The flag is set only once while the count is held. In interval mode, a match value above `interval` never fires. With bit 3 = 0, no match flag is set.
- R9: Status flags are sticky. The edge that samples `stat_rd` = 1 clears them, except for a flag set on that same edge, which survives.
- R10: `irq` is 1 exactly when some status bit is 1 and the matching `ien` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_cfg | input | 5 | Bit 0 prescaler enable, bits 4:1 prescale select N |
| ctrl_we | input | 1 | Counter-control write strobe |
| ctrl_wdata | input | 6 | Counter-control write value (bit 4 = counter reset) |
| ctrl_q | output | 6 | Stored counter control |
| interval | input | 16 | Interval-mode top value |
| match_vals | input | 48 | Three match values, match 1 in the low 16 bits |
| ien | input | 6 | Interrupt enable per status bit |
| stat_rd | input | 1 | Status read strobe, clears the flags |
| count | output | 16 | Current count |
| status | output | 6 | Interrupt status: bit 0 interval, 1..3 match, 4 overflow, 5 event (always 0) |
| irq | output | 1 | Combined interrupt |

## Verification
The bench uses the default parameters: a 16-bit counter and a 4-bit prescale select. At these values, a full 65536-step wrap fits easily in the run, so the overflow from 0xFFFF to 0 is exercised directly rather than on a narrowed counter. The prescaler is checked at divide ratios 4 and 8, with a nonzero select but the enable bit off. A status read is timed to land on the same edge as an interval wrap.

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int CW = 16,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW:0]   clk_cfg,
  input  logic          ctrl_we,
  input  logic [5:0]    ctrl_wdata,
  output logic [5:0]    ctrl_q,
  input  logic [CW-1:0] interval,
  input  logic [3*CW-1:0] match_vals,
  input  logic [5:0]    ien,
  input  logic          stat_rd,
  output logic [CW-1:0] count,
  output logic [5:0]    status,
  output logic          irq
);
  localparam int DIVW = 2**NW;
  localparam int NM = 3;

  logic [5:0]      ctrl_r;
  logic [CW-1:0]   cnt_r;
  logic [DIVW-1:0] pre_r;
  logic [4:0]      flags_r;
  logic [NM-1:0]   hit;

  wire run   = !ctrl_r[0];
  wire imode = ctrl_r[1];
  wire down  = ctrl_r[2];
  wire men   = ctrl_r[3];

  wire [NW:0]   shamt = {1'b0, clk_cfg[NW:1]} + {{NW{1'b0}}, 1'b1};
  wire [DIVW:0] span  = ({{DIVW{1'b0}}, 1'b1} << shamt) - {{DIVW{1'b0}}, 1'b1};
  wire [DIVW-1:0] pmask = span[DIVW-1:0];
  wire tick = run && (!clk_cfg[0] || ((pre_r & pmask) == pmask));

  wire [CW-1:0] top = imode ? interval : {CW{1'b1}};
  wire wrap_up = cnt_r >= top;
  wire wrap_dn = cnt_r == '0;
  wire wrap    = down ? wrap_dn : wrap_up;
  wire [CW-1:0] nxt = down ? (wrap_dn ? top : cnt_r - 1'b1)
                           : (wrap_up ? '0 : cnt_r + 1'b1);

  wire clr_w = ctrl_we && ctrl_wdata[4];
  wire step  = tick && !clr_w;

  for (genvar i = 0; i < NM; i++) begin : g_cmp
    wire [CW-1:0] mv = match_vals[i*CW +: CW];
    assign hit[i] = step && men && (nxt == mv) && (!imode || mv <= interval);
  end

  wire [4:0] set = {step && wrap && !imode, hit, step && wrap && imode};
  wire [4:0] flags_n = (stat_rd ? 5'd0 : flags_r) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r  <= 6'h21;
      cnt_r   <= '0;
      pre_r   <= '0;
      flags_r <= '0;
    end else begin
      flags_r <= flags_n;
      if (ctrl_we) ctrl_r <= ctrl_wdata & 6'h2F;
      if (clr_w) begin
        cnt_r <= '0;
        pre_r <= '0;
      end else begin
        if (run) pre_r <= pre_r + 1'b1;
        if (step) cnt_r <= nxt;
      end
    end
  end

  assign ctrl_q = ctrl_r;
  assign count  = cnt_r;
  assign status = {1'b0, flags_r};
  assign irq    = |({1'b0, flags_r} & ien);
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_we,
  input logic [5:0]    ctrl_wdata,
  input logic [5:0]    ctrl_q,
  input logic [CW-1:0] interval,
  input logic          stat_rd,
  input logic [CW-1:0] count,
  input logic [5:0]    status
);
  // R2
  reset_write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[4]) |=> (count == '0));

  // R3
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && !ctrl_we) |=> $stable(count));

  // R5
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_we && ctrl_q[2:0] == 3'b000 && count == {CW{1'b1}})
      |=> (count == {CW{1'b1}} || (count == '0 && status[4])));

  // R6
  interval_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_we && ctrl_q[1] && count <= interval) |=> (count <= $past(interval)));

  // R7
  down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_we && ctrl_q[2:0] == 3'b100 && count == '0)
      |=> (count == '0 || (count == {CW{1'b1}} && status[4])));

  // R9
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd) |=> ((status & $past(status)) == $past(status)));
endmodule

bind pit_channel pit_channel_chk #(.CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
  .ctrl_q(ctrl_q), .interval(interval), .stat_rd(stat_rd),
  .count(count), .status(status)
);

// File: tb/pit_channel_test.sv
`timescale 1ns/1ps
module pit_channel_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [4:0]  clk_cfg = '0;
  logic        ctrl_we = 0;
  logic [5:0]  ctrl_wdata = '0;
  logic [5:0]  ctrl_q;
  logic [15:0] interval = '0;
  logic [47:0] match_vals = '0;
  logic [5:0]  ien = '0;
  logic        stat_rd = 0;
  logic [15:0] count;
  logic [5:0]  status;
  logic        irq;
  int total = 0, bad = 0, cyc = 0;

  pit_channel uut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [5:0] v);
    ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_stat();
    stat_rd = 1;
    @(negedge clk);
    stat_rd = 0;
  endtask

  task automatic t_reset();
    chk("R1 ctrl", ctrl_q, 6'h21);
    chk("R1 count", count, 0);
    chk("R1 status", status, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_ctrl();
    wr_ctrl(6'h3F);
    chk("R2 bit4 not stored", ctrl_q, 6'h2F);
    chk("R2 count", count, 0);
    wr_ctrl(6'h21);
  endtask

  task automatic t_free();
    wr_ctrl(6'h10);
    wait_n(10);
    chk("R5 up count", count, 10);
    wr_ctrl(6'h01);
    chk("R3 last step", count, 11);
    wait_n(5);
    chk("R3 held", count, 11);
    wr_ctrl(6'h11);
    chk("R2 reset bit zeroes", count, 0);
    wr_ctrl(6'h10);
    wait_n(65535);
    chk("R5 top", count, 16'hFFFF);
    chk("R5 no flag yet", status, 0);
    wait_n(1);
    chk("R5 wrap", count, 0);
    chk("R5 overflow flag", status, 6'h10);
    wr_ctrl(6'h01);
    rd_stat();
    chk("R9 cleared", status, 0);
  endtask

  task automatic t_presc();
    clk_cfg = 5'b00011;
    wr_ctrl(6'h10);
    wait_n(3);
    chk("R4 div4 before", count, 0);
    wait_n(1);
    chk("R4 div4 first", count, 1);
    wait_n(4);
    chk("R4 div4 second", count, 2);
    wr_ctrl(6'h11);
    clk_cfg = 5'b00101;
    wr_ctrl(6'h10);
    wait_n(7);
    chk("R4 div8 before", count, 0);
    wait_n(1);
    chk("R4 div8 first", count, 1);
    wr_ctrl(6'h11);
    clk_cfg = 5'b00100;
    wr_ctrl(6'h10);
    wait_n(3);
    chk("R4 prescaler off", count, 3);
    clk_cfg = '0;
    wr_ctrl(6'h11);
  endtask

  task automatic t_interval();
    interval = 16'd4;
    wr_ctrl(6'h12);
    wait_n(4);
    chk("R6 at interval", count, 4);
    chk("R6 no flag yet", status, 0);
    wait_n(1);
    chk("R6 restart", count, 0);
    chk("R6 interval flag", status, 6'h01);
    wr_ctrl(6'h13);
    rd_stat();
  endtask

  task automatic t_down();
    wr_ctrl(6'h16);
    wait_n(1);
    chk("R7 down to interval", count, 4);
    chk("R7 interval flag", status, 6'h01);
    wait_n(4);
    chk("R7 down to zero", count, 0);
    wr_ctrl(6'h11);
    rd_stat();
    wr_ctrl(6'h14);
    wait_n(1);
    chk("R7 down to full top", count, 16'hFFFF);
    chk("R7 overflow flag", status, 6'h10);
    wr_ctrl(6'h11);
    rd_stat();
  endtask

  task automatic t_match();
    interval = 16'd9;
    match_vals = {16'd12, 16'd7, 16'd3};
    wr_ctrl(6'h1A);
    wait_n(10);
    chk("R8 period count", count, 0);
    chk("R8 matches 1,2 not 3", status, 6'h07);
    wr_ctrl(6'h1B);
    rd_stat();
    wr_ctrl(6'h1A);
    wait_n(2);
    wr_ctrl(6'h0B);
    chk("R8 held at match", count, 3);
    chk("R8 match1 flag", status, 6'h02);
    rd_stat();
    wait_n(5);
    chk("R8 no repeat while held", status, 0);
    wr_ctrl(6'h13);
    wr_ctrl(6'h12);
    wait_n(3);
    chk("R8 enable off count", count, 3);
    chk("R8 enable off no flag", status, 0);
    wr_ctrl(6'h13);
  endtask

  task automatic t_race();
    interval = 16'd4;
    wr_ctrl(6'h12);
    wait_n(4);
    chk("R9 pre-race count", count, 4);
    rd_stat();
    chk("R9 same-edge flag survives", status, 6'h01);
    wr_ctrl(6'h13);
  endtask

  task automatic t_irq();
    ien = 6'h00; #1;
    chk("R10 disabled", irq, 0);
    ien = 6'h01; #1;
    chk("R10 enabled", irq, 1);
    ien = 6'h3E; #1;
    chk("R10 other bits", irq, 0);
    ien = 6'h01;
    @(negedge clk);
    rd_stat();
    chk("R10 after clear", irq, 0);
    chk("R9 status after clear", status, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_free();
    t_presc();
    t_interval();
    t_down();
    t_match();
    t_race();
    t_irq();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule